// File: doc/BRIEF.md
# Programmable Output Clock Divider

This block turns a fast source clock into one divided output clock. It takes an even division setting and a mode control. In normal mode every source cycle advances the divider. The high/low split follows a fixed rule that depends on the setting: an exact half split where that is possible, and a high phase one source cycle short for the other settings. In bypass mode the divider advances only on strobes from an upstream reference divider. The ratio is then half the setting, and a ratio of one passes the strobe stream straight through.

Several instances can hang off one source clock and one synchronous reset. After release they all begin a high phase on the same source cycle, so their outputs stay phase-aligned wherever their periods share a common multiple. A new setting or mode is only adopted at an output period boundary, so the output never carries a runt pulse. Settings that are odd or out of range are clamped, and this raises a one-cycle error pulse.

Top module: `clk_div_out`

## Requirements
- R1: `div_set` is an unsigned binary integer. In normal mode (`bypass`=0), a setting V of 2 or of a multiple of 4 gives V/2 source cycles high and V/2 low.
- R2: In normal mode, a setting V = 4k+2 with k≥1 gives V/2−1 source cycles high and V/2+1 low.
- R3: In bypass mode with N = V/2 ≥ 2, only source cycles with `ref_tick`=1 advance the divider. The output stays high for floor(N/2) strobes and low for N−floor(N/2) strobes.
- R4: In bypass mode with V = 2, `clk_out` equals `ref_tick` delayed by one source cycle.
- R5: `lock_ok` is 1 once normal mode is the active mode, and 0 while bypass is active. It changes only at a period boundary.
- R6: A change of `div_set` or `bypass` takes effect only at the next output period boundary. The period in progress completes with the old setting.
- R7: A setting below 2 becomes 2, one above 64 becomes 64, and an odd in-range value becomes the value minus one. `set_err` pulses for one cycle on the first cycle after reset, or after a change, on which an illegal setting is presented.
- R8: While `rst`=1 the outputs `clk_out`, `lock_ok` and `set_err` are 0. On the first clock edge after release, `clk_out` goes high, so instances released together rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| div_set | input | 7 | Requested division setting V |
| bypass | input | 1 | 1 selects bypass mode (ratio V/2, strobe-driven) |
| ref_tick | input | 1 | One-cycle strobe from the upstream reference divider |
| clk_out | output | 1 | Divided output clock |
| lock_ok | output | 1 | Lock/skew-valid flag, low in bypass |
| set_err | output | 1 | One-cycle pulse for a clamped setting |

## Verification
The assertions assume that `ref_tick` is a clean one-cycle strobe synchronous to `clk`, and that `div_set` and `bypass` are synchronous levels that may change on any cycle. The bench drives every input on the falling clock edge, so nothing changes near the sampling edge. It produces the reference strobe once every three source cycles, which makes every bypass duration an exact multiple of three cycles. Settings change only while the block is held in reset, except in the directed tests that deliberately change the setting mid-period.

// File: rtl/div_pkg.sv
package div_pkg;

   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_BYPASS = 1'b1
   } div_mode_e;

   localparam int DIV_MIN_LEGAL = 2;

endpackage

// File: rtl/div_clamp.sv
module div_clamp
   import div_pkg::*;
#(
   parameter int VMAX     = 64,
   parameter int ODD_UP   = 0,
   parameter int VW       = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [VW-1:0] set_in,
   output logic [VW-1:0] set_ok,
   output logic          err_o
);

   localparam logic [VW-1:0] LO_LIM = VW'(DIV_MIN_LEGAL);
   localparam logic [VW-1:0] HI_LIM = VW'(VMAX);

   logic          illegal;
   logic [VW-1:0] odd_fix;
   logic [VW-1:0] prev_q;
   logic          err_q;

   if ((VMAX % 2) != 0 || VMAX < DIV_MIN_LEGAL) begin : g_bad_vmax
      $error("div_clamp: VMAX must be even and at least 2");
   end

   assign illegal = (set_in < LO_LIM) || (set_in > HI_LIM) || set_in[0];

   if (ODD_UP != 0) begin : g_odd_up
      assign odd_fix = (set_in >= HI_LIM) ? HI_LIM : set_in + VW'(1);
   end else begin : g_odd_down
      assign odd_fix = set_in - VW'(1);
   end

   always_comb begin
      if (set_in < LO_LIM)      set_ok = LO_LIM;
      else if (set_in > HI_LIM) set_ok = HI_LIM;
      else if (set_in[0])       set_ok = odd_fix;
      else                      set_ok = set_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= LO_LIM;
         err_q  <= 1'b0;
      end else begin
         prev_q <= set_in;
         err_q  <= illegal && (set_in != prev_q);
      end
   end

   assign err_o = err_q;

   // R7: an error pulse needs an illegal setting on the cycle before
   p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
      err_o |-> $past(illegal));

endmodule

// File: rtl/div_pattern.sv
module div_pattern
   import div_pkg::*;
#(
   parameter int VW = 7
) (
   input  div_mode_e     mode,
   input  logic [VW-1:0] v,
   output logic [VW-1:0] period,
   output logic [VW-1:0] high,
   output logic          pass
);

   logic [VW-1:0] half;

   assign half = v >> 1;

   always_comb begin
      pass = 1'b0;
      if (mode == MODE_NORMAL) begin
         period = v;
         high   = (v == VW'(2) || v[1:0] == 2'b00) ? half : half - VW'(1);
      end else if (half == VW'(1)) begin
         period = VW'(1);
         high   = VW'(1);
         pass   = 1'b1;
      end else begin
         period = half;
         high   = half >> 1;
      end
   end

endmodule

// File: rtl/div_core.sv
module div_core
   import div_pkg::*;
#(
   parameter int VW = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick_ext,
   input  div_mode_e     nxt_mode,
   input  logic [VW-1:0] nxt_period,
   input  logic [VW-1:0] nxt_high,
   input  logic          nxt_pass,
   output logic          out_clk,
   output div_mode_e     mode_q,
   output logic          started_q
);

   logic [VW-1:0] cnt_q;
   logic [VW-1:0] cur_period;
   logic [VW-1:0] cur_high;
   logic          pass_q;
   logic          out_q;
   logic          tick;
   logic          wrap;
   logic [VW-1:0] cnt_nx;

   assign tick   = (!started_q || mode_q == MODE_NORMAL) ? 1'b1 : tick_ext;
   assign wrap   = !started_q || (cnt_q == cur_period - VW'(1));
   assign cnt_nx = cnt_q + VW'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q      <= '0;
         out_q      <= 1'b0;
         started_q  <= 1'b0;
         mode_q     <= MODE_NORMAL;
         cur_period <= VW'(2);
         cur_high   <= VW'(1);
         pass_q     <= 1'b0;
      end else if (tick) begin
         if (wrap) begin
            cnt_q      <= '0;
            out_q      <= (nxt_high != '0);
            started_q  <= 1'b1;
            mode_q     <= nxt_mode;
            cur_period <= nxt_period;
            cur_high   <= nxt_high;
            pass_q     <= nxt_pass;
         end else begin
            cnt_q <= cnt_nx;
            out_q <= (cnt_nx < cur_high);
         end
      end else if (pass_q) begin
         out_q <= 1'b0;
      end
   end

   assign out_clk = out_q;

   // R6: the count never leaves the latched period
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
      started_q |-> (cnt_q < cur_period));

   // R6: latched settings hold for the whole period
   p_hold_mid_r6: assert property (@(posedge clk) disable iff (rst)
      (started_q && !(tick && wrap)) |=> ($stable(cur_period) && $stable(cur_high) && $stable(mode_q)));

   // R8: the first period after release opens with a high phase
   p_start_high_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(started_q) |-> out_q);

   // R3: in bypass the count moves only on a strobe
   p_byp_stall_r3: assert property (@(posedge clk) disable iff (rst)
      (started_q && mode_q == MODE_BYPASS && !tick_ext) |=> $stable(cnt_q));

endmodule

// File: rtl/clk_div_out.sv
module clk_div_out
   import div_pkg::*;
#(
   parameter int VMAX         = 64,
   parameter int ODD_ROUND_UP = 0,
   localparam int VW          = $clog2(VMAX + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [VW-1:0] div_set,
   input  logic          bypass,
   input  logic          ref_tick,
   output logic          clk_out,
   output logic          lock_ok,
   output logic          set_err
);

   logic [VW-1:0] v_legal;
   logic [VW-1:0] pat_period;
   logic [VW-1:0] pat_high;
   logic          pat_pass;
   div_mode_e     req_mode;
   div_mode_e     act_mode;
   logic          started;

   assign req_mode = bypass ? MODE_BYPASS : MODE_NORMAL;

   div_clamp #(.VMAX(VMAX), .ODD_UP(ODD_ROUND_UP), .VW(VW)) clamp_i (
      .clk    (clk),
      .rst    (rst),
      .set_in (div_set),
      .set_ok (v_legal),
      .err_o  (set_err)
   );

   div_pattern #(.VW(VW)) pat_i (
      .mode   (req_mode),
      .v      (v_legal),
      .period (pat_period),
      .high   (pat_high),
      .pass   (pat_pass)
   );

   div_core #(.VW(VW)) core_i (
      .clk        (clk),
      .rst        (rst),
      .tick_ext   (ref_tick),
      .nxt_mode   (req_mode),
      .nxt_period (pat_period),
      .nxt_high   (pat_high),
      .nxt_pass   (pat_pass),
      .out_clk    (clk_out),
      .mode_q     (act_mode),
      .started_q  (started)
   );

   assign lock_ok = started && (act_mode == MODE_NORMAL);

   // R5: the flag drops only when bypass was requested at that edge
   p_lock_drop_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(lock_ok) |-> $past(bypass));

   // R5: the flag rises only when normal mode was requested at that edge
   p_lock_rise_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(lock_ok) |-> !$past(bypass));

endmodule

// File: tb/clk_div_out_tb_top.sv
module clk_div_out_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [6:0] div_set = 7'd2;
   logic [6:0] div_b = 7'd6;
   logic       bypass = 1'b0;
   logic       ref_tick = 1'b0;
   logic       clk_out, lock_ok, set_err;
   logic       out_b, lock_b, err_b;
   int         checks = 0;
   int         errors = 0;
   int         tph = 0;

   always #2.5 clk = ~clk;

   clk_div_out dut_i (.clk(clk), .rst(rst), .div_set(div_set), .bypass(bypass),
      .ref_tick(ref_tick), .clk_out(clk_out), .lock_ok(lock_ok), .set_err(set_err));

   clk_div_out dut_b (.clk(clk), .rst(rst), .div_set(div_b), .bypass(1'b0),
      .ref_tick(ref_tick), .clk_out(out_b), .lock_ok(lock_b), .set_err(err_b));

   // input, expected high, expected low, expected error pulse
   localparam int NV = 8;
   localparam int CLAMP_TAB [NV][4] = '{
      '{0, 1, 1, 1}, '{1, 1, 1, 1}, '{7, 2, 4, 1}, '{33, 16, 16, 1},
      '{65, 32, 32, 1}, '{100, 32, 32, 1}, '{127, 32, 32, 1}, '{64, 32, 32, 0}};

   initial begin
      forever begin
         @(negedge clk);
         tph = (tph == 2) ? 0 : tph + 1;
         ref_tick = (tph == 0);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic start(input int v, input logic bp);
      rst = 1'b1;
      div_set = 7'(v);
      bypass = bp;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_rise();
      logic p;
      p = clk_out;
      for (int g = 0; g < 2000; g++) begin
         @(negedge clk);
         if (clk_out && !p) return;
         p = clk_out;
      end
      check("rise timeout", 0, 1);
   endtask

   task automatic meas_from_rise(output int hi, output int lo);
      hi = 1;
      lo = 0;
      for (int g = 0; g < 2000; g++) begin
         @(negedge clk);
         if (clk_out) hi++; else break;
      end
      for (int g = 0; g < 2000; g++) begin
         if (!clk_out) lo++; else break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int hi, lo, eh, el, n;
      int co;
      logic pa, pb;

      // R8: reset state
      repeat (2) @(negedge clk);
      check("R8 reset clk_out", int'(clk_out), 0);
      check("R8 reset lock_ok", int'(lock_ok), 0);
      check("R8 reset set_err", int'(set_err), 0);

      // R8: common release, aligned rises (V=8 and V=6, common multiple 24)
      div_b = 7'd6;
      start(8, 1'b0);
      co = 0; pa = 1'b0; pb = 1'b0;
      for (int k = 1; k <= 48; k++) begin
         @(negedge clk);
         if (k == 1) begin
            check("R8 first rise dut_i", int'(clk_out), 1);
            check("R8 first rise dut_b", int'(out_b), 1);
         end
         if (clk_out && !pa && out_b && !pb) co++;
         pa = clk_out;
         pb = out_b;
      end
      check("R8 coincident rises in 48 cycles", co, 2);

      // R1 R2 R3 R4 R5: every legal setting in both modes
      for (int v = 2; v <= 64; v += 2) begin
         for (int b = 0; b < 2; b++) begin
            start(v, b[0]);
            wait_rise();
            meas_from_rise(hi, lo);
            meas_from_rise(hi, lo);
            if (b == 0) begin
               eh = (v == 2 || v % 4 == 0) ? v / 2 : v / 2 - 1;
               el = v - eh;
               if (eh * 2 == v) begin
                  check($sformatf("R1 high V=%0d", v), hi, eh);
                  check($sformatf("R1 low V=%0d", v), lo, el);
               end else begin
                  check($sformatf("R2 high V=%0d", v), hi, eh);
                  check($sformatf("R2 low V=%0d", v), lo, el);
               end
            end else begin
               n = v / 2;
               if (n == 1) begin
                  check("R4 pass-through high", hi, 1);
                  check("R4 pass-through low", lo, 2);
               end else begin
                  check($sformatf("R3 high V=%0d", v), hi, 3 * (n / 2));
                  check($sformatf("R3 low V=%0d", v), lo, 3 * (n - n / 2));
               end
            end
            check($sformatf("R5 lock V=%0d bypass=%0d", v, b), int'(lock_ok), 1 - b);
         end
      end

      // R7: clamp table walk
      for (int i = 0; i < NV; i++) begin
         start(CLAMP_TAB[i][0], 1'b0);
         @(negedge clk);
         check($sformatf("R7 err pulse in=%0d", CLAMP_TAB[i][0]), int'(set_err), CLAMP_TAB[i][3]);
         @(negedge clk);
         check($sformatf("R7 err cleared in=%0d", CLAMP_TAB[i][0]), int'(set_err), 0);
         wait_rise();
         meas_from_rise(hi, lo);
         meas_from_rise(hi, lo);
         check($sformatf("R7 high in=%0d", CLAMP_TAB[i][0]), hi, CLAMP_TAB[i][1]);
         check($sformatf("R7 low in=%0d", CLAMP_TAB[i][0]), lo, CLAMP_TAB[i][2]);
      end

      // R7: a new illegal value pulses again, a held one does not
      div_set = 7'd9;
      @(negedge clk);
      check("R7 new illegal value", int'(set_err), 1);
      repeat (2) @(negedge clk);
      check("R7 held illegal value", int'(set_err), 0);

      // R6: mid-period change of setting
      start(8, 1'b0);
      wait_rise();
      div_set = 7'd16;
      meas_from_rise(hi, lo);
      check("R6 old period high", hi, 4);
      check("R6 old period low", lo, 4);
      meas_from_rise(hi, lo);
      check("R6 new period high", hi, 8);
      check("R6 new period low", lo, 8);

      // R5 R6: mid-period bypass request waits for the boundary
      start(16, 1'b0);
      wait_rise();
      bypass = 1'b1;
      @(negedge clk);
      check("R5 lock holds mid-period", int'(lock_ok), 1);
      for (int g = 0; g < 100; g++) begin
         @(negedge clk);
         if (!clk_out) break;
      end
      check("R6 old high kept after bypass request", int'(lock_ok), 1);
      wait_rise();
      @(negedge clk);
      check("R5 lock low in bypass", int'(lock_ok), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule